// File: doc/BRIEF.md
# Flash Sector-Protection Command Decoder

This block sits on the device side of a byte-wide flash write bus and turns sequences of address/data write cycles into protection operations. From array-read mode, a three-write unlock handshake selects one of five protection sub-modes: lock register, password, non-volatile sector bits, the freeze bit, or volatile sector bits. Inside a sub-mode the host programs bits, erases the non-volatile bits, runs a password unlock, or reads one protection bit back on DQ0. A two-write exit sequence returns to array read.

The block holds a small protection model: one non-volatile and one volatile bit per sector, a freeze bit, an eight-bit one-way lock register and a 64-bit password with a comparison unit. Any write that breaks a sequence parks the decoder in an error mode that only the reset command leaves. Array timing and cell behaviour are not modelled.

Top module: `sprot_cmd_decoder`

## Requirements
- R1: Sub-mode entry needs three writes from array-read mode: data AA at address AAA, 55 at 555, then a code at AAA, where 40 selects lock register (mode 1), 60 password (mode 2), C0 non-volatile bits (mode 3), 50 freeze (mode 4) and E0 volatile bits (mode 5); `mode_o` shows the new value one clock after the third write, array read being mode 0.
- R2: In any sub-mode, a write of 90 (any address) followed by a write of 00 (any address) returns `mode_o` to 0.
- R3: In lock-register mode, A0 then a data byte D ANDs D into the register (reset value FF), so bits only go from 1 to 0; a read at address bits [2:0] = n returns bit n.
- R4: A read (`rd_en` high, `wr_en` low) updates `dq0` one clock later; in sector modes `dq0` is 0 for a protected sector and 1 for an unprotected one, the sector being address bits [11:9]; without a read `dq0` holds; in array-read mode a read returns 1.
- R5: In password mode, A0 then a write at address bits [2:0] = k stores byte k of the password (a read at address bits [5:0] returns that password bit); the unlock is 25, then exactly eight portion writes in any order, then 29, after which `pw_ok` is 1 only if every portion was presented and all matched.
- R6: In non-volatile mode, 80 then 30 at address 000 first sets every non-volatile bit for one clock, then clears all of them on the next clock.
- R7: In volatile mode, A0 then 00 at a sector address protects that sector and A0 then 01 unprotects it.
- R8: Setting a non-volatile or volatile bit takes effect only while `acc_hi` is 1; clearing a volatile bit does not depend on it.
- R9: In freeze mode, A0 then 00 sets the freeze bit (read back as `dq0` 0); while it is set, non-volatile programs and erases have no effect, and setting it changes no existing bit.
- R10: A write that breaks a sequence (wrong unlock address or data, unknown command, program data not allowed in the mode, wrong erase or confirm byte) sets `mode_o` to 6 and it stays there until a write of F0; F0 acts as reset command only in a command position, never as program or password data.
- R11: After `rst`, `mode_o` is 0, `dq0` is 1, `pw_ok` is 0, all sector bits and freeze are clear and the lock register is FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per clock |
| rd_en | input | 1 | Read strobe for a status bit |
| addr | input | 12 | Bus address |
| wdata | input | 8 | Write data byte |
| acc_hi | input | 1 | Accelerate pin level, enables bit setting |
| dq0 | output | 1 | Registered status bit from the last read |
| mode_o | output | 3 | Current decoder mode |
| pw_ok | output | 1 | Result of the last password unlock |

## Verification
A wrong sequencer step shows on `mode_o` on the clock after the offending write, either as a premature mode change or as an unexpected jump to the error mode. Corrupted protection bits, lock bits or password bytes stay invisible until a status read in the matching mode, so the bench reads every affected sector or bit after each operation and sees the fault one clock after that read. A faulty portion tracker appears only on `pw_ok` after the confirm byte, so the unlock is tried with a shuffled, a wrong and a repeated-portion presentation.

// File: rtl/sprot_pkg.sv
package sprot_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        M_READ = 3'd0,
        M_LOCK = 3'd1,
        M_PASS = 3'd2,
        M_NV   = 3'd3,
        M_FRZ  = 3'd4,
        M_VOL  = 3'd5,
        M_ERR  = 3'd6
    } mode_e;

    typedef enum logic [2:0] {
        S_IDLE, S_UNL1, S_UNL2, S_PROG, S_EXIT, S_ERA, S_PWU
    } step_e;

    typedef enum logic [2:0] {
        C_NONE, C_PROG, C_ERASE, C_PWSTART, C_PWBYTE, C_PWCHK
    } cmd_e;

    typedef struct packed {
        cmd_e                kind;
        mode_e               mode;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
    } cmd_t;

    localparam logic [ADDR_W-1:0] ADR_FIRST  = 12'hAAA;
    localparam logic [ADDR_W-1:0] ADR_SECOND = 12'h555;
    localparam logic [DATA_W-1:0] K_UNL1  = 8'hAA;
    localparam logic [DATA_W-1:0] K_UNL2  = 8'h55;
    localparam logic [DATA_W-1:0] K_EXIT  = 8'h90;
    localparam logic [DATA_W-1:0] K_ZERO  = 8'h00;
    localparam logic [DATA_W-1:0] K_PROG  = 8'hA0;
    localparam logic [DATA_W-1:0] K_ERA   = 8'h80;
    localparam logic [DATA_W-1:0] K_ERAOK = 8'h30;
    localparam logic [DATA_W-1:0] K_PWU   = 8'h25;
    localparam logic [DATA_W-1:0] K_PWCHK = 8'h29;
    localparam logic [DATA_W-1:0] K_RST   = 8'hF0;

    function automatic mode_e mode_from_code(input logic [DATA_W-1:0] c);
        case (c)
            8'h40:   return M_LOCK;
            8'h60:   return M_PASS;
            8'hC0:   return M_NV;
            8'h50:   return M_FRZ;
            8'hE0:   return M_VOL;
            default: return M_ERR;
        endcase
    endfunction

    function automatic logic prog_data_ok(input mode_e m, input logic [DATA_W-1:0] d);
        case (m)
            M_NV, M_FRZ: return d == 8'h00;
            M_VOL:       return (d == 8'h00) || (d == 8'h01);
            default:     return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/sprot_seq.sv
module sprot_seq
    import sprot_pkg::*;
#(
    parameter int PW_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output mode_e             mode_o,
    output cmd_t              cmd_o
);
    localparam int CNT_W = $clog2(PW_BYTES + 1);

    mode_e            mode_q, mode_n;
    step_e            step_q, step_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    always_comb begin
        mode_n = mode_q;
        step_n = step_q;
        cnt_n  = cnt_q;
        cmd_o  = '{kind: C_NONE, mode: mode_q, addr: addr, data: wdata};
        if (wr_en) begin
            if (wdata == K_RST && (mode_q == M_ERR || step_q inside {S_IDLE, S_UNL1, S_UNL2})) begin
                mode_n = M_READ;
                step_n = S_IDLE;
            end else if (mode_q == M_ERR) begin
                mode_n = M_ERR;
            end else if (mode_q == M_READ) begin
                mode_n = M_ERR;
                step_n = S_IDLE;
                case (step_q)
                    S_IDLE: if (addr == ADR_FIRST && wdata == K_UNL1) begin
                        mode_n = M_READ; step_n = S_UNL1;
                    end
                    S_UNL1: if (addr == ADR_SECOND && wdata == K_UNL2) begin
                        mode_n = M_READ; step_n = S_UNL2;
                    end
                    S_UNL2: if (addr == ADR_FIRST) mode_n = mode_from_code(wdata);
                    default: ;
                endcase
            end else begin
                step_n = S_IDLE;
                case (step_q)
                    S_IDLE: begin
                        if (wdata == K_EXIT)                          step_n = S_EXIT;
                        else if (wdata == K_PROG)                     step_n = S_PROG;
                        else if (mode_q == M_NV && wdata == K_ERA)    step_n = S_ERA;
                        else if (mode_q == M_PASS && wdata == K_PWU) begin
                            step_n     = S_PWU;
                            cnt_n      = '0;
                            cmd_o.kind = C_PWSTART;
                        end else mode_n = M_ERR;
                    end
                    S_EXIT:  mode_n = (wdata == K_ZERO) ? M_READ : M_ERR;
                    S_PROG:  if (prog_data_ok(mode_q, wdata)) cmd_o.kind = C_PROG;
                             else mode_n = M_ERR;
                    S_ERA:   if (wdata == K_ERAOK && addr == '0) cmd_o.kind = C_ERASE;
                             else mode_n = M_ERR;
                    S_PWU: begin
                        if (int'(cnt_q) < PW_BYTES) begin
                            cmd_o.kind = C_PWBYTE;
                            cnt_n      = cnt_q + 1'b1;
                            step_n     = S_PWU;
                        end else if (wdata == K_PWCHK) cmd_o.kind = C_PWCHK;
                        else mode_n = M_ERR;
                    end
                    default: mode_n = M_ERR;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_READ;
            step_q <= S_IDLE;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_n;
            step_q <= step_n;
            cnt_q  <= cnt_n;
        end
    end

    assign mode_o = mode_q;

    // R1
    entry_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_READ && !(wr_en && step_q == S_UNL2)) |=> (mode_q inside {M_READ, M_ERR}));

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_ERR && !(wr_en && wdata == K_RST)) |=> (mode_q == M_ERR));

    // R2
    exit_done_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && step_q == S_EXIT && mode_q != M_READ && mode_q != M_ERR && wdata == K_ZERO)
        |=> (mode_q == M_READ));

endmodule

// File: rtl/sprot_bits.sv
module sprot_bits
    import sprot_pkg::*;
#(
    parameter int NUM_SECT = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  cmd_t                cmd_i,
    input  logic                acc_hi,
    output logic [NUM_SECT-1:0] nv_o,
    output logic [NUM_SECT-1:0] vol_o,
    output logic                frz_o,
    output logic [7:0]          lock_o
);
    localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;

    logic [NUM_SECT-1:0] nv_q, vol_q;
    logic                frz_q, erase_q;
    logic [7:0]          lock_q;
    logic [SECT_W-1:0]   sect;
    logic                prog, erase_go, nv_set, vol_set, vol_clr;

    assign sect     = cmd_i.addr[ADDR_W-1 -: SECT_W];
    assign prog     = (cmd_i.kind == C_PROG);
    assign erase_go = (cmd_i.kind == C_ERASE) && (cmd_i.mode == M_NV) && !frz_q;
    assign nv_set   = prog && (cmd_i.mode == M_NV) && acc_hi && !frz_q;
    assign vol_set  = prog && (cmd_i.mode == M_VOL) && acc_hi && (cmd_i.data == 8'h00);
    assign vol_clr  = prog && (cmd_i.mode == M_VOL) && (cmd_i.data == 8'h01);

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
        logic hit;
        assign hit = (sect == SECT_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                nv_q[g]  <= 1'b0;
                vol_q[g] <= 1'b0;
            end else begin
                if (erase_q)              nv_q[g] <= 1'b0;
                else if (erase_go)        nv_q[g] <= 1'b1;
                else if (nv_set && hit)   nv_q[g] <= 1'b1;
                if (vol_set && hit)       vol_q[g] <= 1'b1;
                else if (vol_clr && hit)  vol_q[g] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frz_q   <= 1'b0;
            erase_q <= 1'b0;
            lock_q  <= 8'hFF;
        end else begin
            erase_q <= erase_go;
            if (prog && cmd_i.mode == M_FRZ)  frz_q  <= 1'b1;
            if (prog && cmd_i.mode == M_LOCK) lock_q <= lock_q & cmd_i.data;
        end
    end

    assign nv_o   = nv_q;
    assign vol_o  = vol_q;
    assign frz_o  = frz_q;
    assign lock_o = lock_q;

    // R6
    erase_clear_chk: assert property (@(posedge clk) disable iff (rst)
        erase_q |=> (nv_q == '0));

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frz_q && !erase_q) |=> $stable(nv_q));

    // R8
    acc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!acc_hi && !erase_q && cmd_i.kind != C_ERASE) |=> ((nv_q & ~$past(nv_q)) == '0));

    // R3
    lock_oneway_chk: assert property (@(posedge clk) disable iff (rst)
        (prog && cmd_i.mode == M_LOCK) |=> ((lock_q & ~$past(lock_q)) == 8'h00));

endmodule

// File: rtl/sprot_pw.sv
module sprot_pw
    import sprot_pkg::*;
#(
    parameter int                    PW_BYTES = 8,
    parameter logic [PW_BYTES*8-1:0] PW_INIT  = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  cmd_t                  cmd_i,
    output logic [PW_BYTES*8-1:0] pw_o,
    output logic                  ok_o
);
    localparam int IDX_W = (PW_BYTES > 1) ? $clog2(PW_BYTES) : 1;

    logic [IDX_W-1:0]    idx;
    logic [PW_BYTES-1:0] seen_q, match_q;
    logic                ok_q;

    assign idx = cmd_i.addr[IDX_W-1:0];

    for (genvar b = 0; b < PW_BYTES; b++) begin : g_byte
        logic sel;
        assign sel = (idx == IDX_W'(b));
        always_ff @(posedge clk) begin
            if (rst) begin
                pw_o[b*8 +: 8] <= PW_INIT[b*8 +: 8];
                seen_q[b]      <= 1'b0;
                match_q[b]     <= 1'b0;
            end else begin
                if (cmd_i.kind == C_PROG && cmd_i.mode == M_PASS && sel)
                    pw_o[b*8 +: 8] <= cmd_i.data;
                if (cmd_i.kind == C_PWSTART) begin
                    seen_q[b]  <= 1'b0;
                    match_q[b] <= 1'b0;
                end else if (cmd_i.kind == C_PWBYTE && sel) begin
                    seen_q[b]  <= 1'b1;
                    match_q[b] <= (cmd_i.data == pw_o[b*8 +: 8]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                        ok_q <= 1'b0;
        else if (cmd_i.kind == C_PWCHK) ok_q <= (&seen_q) && (&match_q);
    end

    assign ok_o = ok_q;

    // R5
    pw_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!ok_q && cmd_i.kind != C_PWCHK) |=> !ok_q);

endmodule

// File: rtl/sprot_cmd_decoder.sv
module sprot_cmd_decoder
    import sprot_pkg::*;
#(
    parameter int                    NUM_SECT = 8,
    parameter int                    PW_BYTES = 8,
    parameter logic [PW_BYTES*8-1:0] PW_INIT  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              acc_hi,
    output logic              dq0,
    output logic [2:0]        mode_o,
    output logic              pw_ok
);
    localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
    localparam int PWB_W  = $clog2(PW_BYTES * 8);

    mode_e                 mode;
    cmd_t                  cmd;
    logic [NUM_SECT-1:0]   nv, vol;
    logic                  frz;
    logic [7:0]            lock;
    logic [PW_BYTES*8-1:0] pw;
    logic                  rd_bit, dq0_q;
    logic [SECT_W-1:0]     sect;

    sprot_seq #(.PW_BYTES(PW_BYTES)) u_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .mode_o(mode), .cmd_o(cmd)
    );

    sprot_bits #(.NUM_SECT(NUM_SECT)) u_bits (
        .clk(clk), .rst(rst), .cmd_i(cmd), .acc_hi(acc_hi),
        .nv_o(nv), .vol_o(vol), .frz_o(frz), .lock_o(lock)
    );

    sprot_pw #(.PW_BYTES(PW_BYTES), .PW_INIT(PW_INIT)) u_pw (
        .clk(clk), .rst(rst), .cmd_i(cmd), .pw_o(pw), .ok_o(pw_ok)
    );

    assign sect = addr[ADDR_W-1 -: SECT_W];

    always_comb begin
        rd_bit = 1'b1;
        case (mode)
            M_LOCK: rd_bit = lock[addr[2:0]];
            M_PASS: rd_bit = pw[addr[PWB_W-1:0]];
            M_NV:   if (int'(sect) < NUM_SECT) rd_bit = ~nv[sect];
            M_FRZ:  rd_bit = ~frz;
            M_VOL:  if (int'(sect) < NUM_SECT) rd_bit = ~vol[sect];
            default: rd_bit = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                  dq0_q <= 1'b1;
        else if (rd_en && !wr_en) dq0_q <= rd_bit;
    end

    assign dq0    = dq0_q;
    assign mode_o = mode;

    // R4
    dq0_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && !wr_en) |=> $stable(dq0_q));

endmodule

// File: tb/sprot_cmd_decoder_test.sv
module sprot_cmd_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst = 1, wr_en = 0, rd_en = 0, acc_hi = 1;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic dq0, pw_ok;
    logic [2:0] mode_o;

    int checks = 0, fails = 0, cyc = 0;
    string cur_req = "R11";
    bit started = 0;

    // reference model state
    int  m_mode, m_step, m_cnt;
    bit  m_nv[8], m_vol[8], m_seen[8], m_match[8];
    bit  m_frz, m_era, m_ok, m_dq0;
    bit [7:0] m_lock;
    bit [7:0] m_pw[8];

    sprot_cmd_decoder uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .acc_hi(acc_hi), .dq0(dq0), .mode_o(mode_o), .pw_ok(pw_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int code_mode(bit [7:0] c);
        if (c == 8'h40) return 1;
        if (c == 8'h60) return 2;
        if (c == 8'hC0) return 3;
        if (c == 8'h50) return 4;
        if (c == 8'hE0) return 5;
        return 6;
    endfunction

    task automatic model_write(bit [11:0] a, bit [7:0] d);
        int s = a >> 9;
        if (d == 8'hF0 && (m_mode == 6 || m_step <= 2)) begin
            m_mode = 0; m_step = 0;
        end else if (m_mode == 6) begin
        end else if (m_mode == 0) begin
            if (m_step == 0 && a == 12'hAAA && d == 8'hAA) m_step = 1;
            else if (m_step == 1 && a == 12'h555 && d == 8'h55) m_step = 2;
            else if (m_step == 2 && a == 12'hAAA) begin m_mode = code_mode(d); m_step = 0; end
            else begin m_mode = 6; m_step = 0; end
        end else begin
            case (m_step)
                0: if (d == 8'h90) m_step = 4;
                   else if (d == 8'hA0) m_step = 3;
                   else if (m_mode == 3 && d == 8'h80) m_step = 5;
                   else if (m_mode == 2 && d == 8'h25) begin
                       m_step = 6; m_cnt = 0;
                       foreach (m_seen[i]) begin m_seen[i] = 0; m_match[i] = 0; end
                   end else m_mode = 6;
                4: begin m_step = 0; m_mode = (d == 8'h00) ? 0 : 6; end
                3: begin
                    m_step = 0;
                    case (m_mode)
                        1: m_lock = m_lock & d;
                        2: m_pw[a % 8] = d;
                        3: if (d != 0) m_mode = 6; else if (acc_hi && !m_frz) m_nv[s] = 1;
                        4: if (d != 0) m_mode = 6; else m_frz = 1;
                        5: if (d == 0) begin if (acc_hi) m_vol[s] = 1; end
                           else if (d == 1) m_vol[s] = 0;
                           else m_mode = 6;
                        default: ;
                    endcase
                end
                5: begin
                    m_step = 0;
                    if (d == 8'h30 && a == 0) begin
                        if (!m_frz) begin foreach (m_nv[i]) m_nv[i] = 1; m_era = 1; end
                    end else m_mode = 6;
                end
                6: if (m_cnt < 8) begin
                       m_seen[a % 8] = 1; m_match[a % 8] = (d == m_pw[a % 8]); m_cnt++;
                   end else begin
                       m_step = 0;
                       if (d == 8'h29) begin
                           m_ok = 1;
                           foreach (m_seen[i]) if (!m_seen[i] || !m_match[i]) m_ok = 0;
                       end else m_mode = 6;
                   end
                default: ;
            endcase
        end
    endtask

    function automatic bit model_read(bit [11:0] a);
        int s = a >> 9;
        case (m_mode)
            1: return m_lock[a % 8];
            2: return m_pw[(a % 64) / 8][a % 8];
            3: return !m_nv[s];
            4: return !m_frz;
            5: return !m_vol[s];
            default: return 1;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        started = 1;
        if (rst) begin
            m_mode = 0; m_step = 0; m_cnt = 0; m_frz = 0; m_era = 0; m_ok = 0;
            m_dq0 = 1; m_lock = 8'hFF;
            foreach (m_nv[i]) begin
                m_nv[i] = 0; m_vol[i] = 0; m_seen[i] = 0; m_match[i] = 0; m_pw[i] = 0;
            end
        end else begin
            if (rd_en && !wr_en) m_dq0 = model_read(addr);
            if (m_era) begin foreach (m_nv[i]) m_nv[i] = 0; m_era = 0; end
            if (wr_en) model_write(addr, wdata);
        end
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: run did not finish (req %s) actual cycles=%0d expected<=20000", cur_req, cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    always @(negedge clk) if (started) begin
        checks++;
        if (int'(mode_o) != m_mode || dq0 !== m_dq0 || pw_ok !== m_ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual mode=%0d dq0=%b pw_ok=%b expected mode=%0d dq0=%b pw_ok=%b",
                     cur_req, cyc, mode_o, dq0, pw_ok, m_mode, m_dq0, m_ok);
        end
    end

    task automatic wr(bit [11:0] a, bit [7:0] d);
        @(negedge clk); wr_en = 1; rd_en = 0; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(bit [11:0] a);
        @(negedge clk); rd_en = 1; wr_en = 0; addr = a;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic enter(bit [7:0] code);
        wr(12'hAAA, 8'hAA); wr(12'h555, 8'h55); wr(12'hAAA, code);
    endtask

    task automatic leave();
        wr(12'h3C1, 8'h90); wr(12'h07E, 8'h00);
    endtask

    task automatic prog(bit [11:0] a, bit [7:0] d);
        wr(12'h000, 8'hA0); wr(a, d);
    endtask

    function automatic bit [11:0] sa(int s);
        return 12'(s << 9) | 12'h01F;
    endfunction

    initial begin
        bit [7:0] pwv[8];
        repeat (3) @(negedge clk);
        cur_req = "R11"; rst = 0;
        rd(12'h000); rd(sa(3));

        // R1 / R2: entry into each mode and exit
        cur_req = "R1";
        enter(8'h40); leave(); enter(8'hE0); leave(); enter(8'h50);
        cur_req = "R2"; leave(); rd(12'h000);

        // R3: one-way lock register, F0 as data
        cur_req = "R3";
        enter(8'h40); prog(12'h000, 8'hF5); prog(12'h000, 8'hF0); prog(12'h004, 8'hDF);
        for (int i = 0; i < 8; i++) rd(12'(i));
        leave();

        // R4 / R8 / R6: non-volatile bits, accelerate gating, erase
        cur_req = "R4"; enter(8'hC0);
        prog(sa(2), 8'h00); rd(sa(2)); rd(sa(3));
        cur_req = "R8"; acc_hi = 0; prog(sa(4), 8'h00); rd(sa(4)); acc_hi = 1;
        prog(sa(7), 8'h00);
        cur_req = "R6"; wr(12'h000, 8'h80); wr(12'h000, 8'h30);
        for (int s = 0; s < 8; s++) rd(sa(s));
        acc_hi = 0; wr(12'h000, 8'h80); wr(12'h000, 8'h30); rd(sa(5)); acc_hi = 1;
        prog(sa(1), 8'h00); rd(sa(1));
        leave();

        // R7 / R8: volatile bits
        cur_req = "R7"; enter(8'hE0);
        prog(sa(0), 8'h00); prog(sa(6), 8'h00); rd(sa(0)); rd(sa(6)); rd(sa(5));
        prog(sa(0), 8'h01); rd(sa(0));
        cur_req = "R8"; acc_hi = 0; prog(sa(3), 8'h00); rd(sa(3));
        prog(sa(6), 8'h01); rd(sa(6)); acc_hi = 1;
        leave();

        // R9: freeze
        cur_req = "R9"; enter(8'h50); rd(12'h000); prog(12'h123, 8'h00); rd(12'h000); leave();
        enter(8'hC0); rd(sa(1));
        prog(sa(6), 8'h00); rd(sa(6));
        wr(12'h000, 8'h80); wr(12'h000, 8'h30); rd(sa(1)); rd(sa(2));
        leave();

        // R5: password program, read and unlock
        cur_req = "R5"; enter(8'h60);
        for (int i = 0; i < 8; i++) pwv[i] = 8'(8'h3C + i * 8'h17);
        for (int i = 0; i < 8; i++) prog(12'(i), pwv[i]);
        rd(12'h009); rd(12'h03F); rd(12'h000);
        wr(12'h000, 8'h25);
        for (int i = 0; i < 8; i++) wr(12'((i * 5 + 3) % 8), pwv[(i * 5 + 3) % 8]);
        wr(12'h000, 8'h29);
        wr(12'h000, 8'h25);
        for (int i = 0; i < 8; i++) wr(12'(i), (i == 4) ? ~pwv[i] : pwv[i]);
        wr(12'h000, 8'h29);
        wr(12'h000, 8'h25);
        for (int i = 0; i < 8; i++) wr(12'(i % 7), pwv[i % 7]);
        wr(12'h000, 8'h29);
        wr(12'h000, 8'h25);
        for (int i = 7; i >= 0; i--) wr(12'(i), pwv[i]);
        wr(12'h000, 8'h29);
        leave();

        // R10: error entry, hold and reset command
        cur_req = "R10";
        wr(12'hAAA, 8'hAA); wr(12'h123, 8'h55); wr(12'h000, 8'h90); wr(12'h000, 8'h00);
        rd(12'h000); wr(12'h777, 8'hF0);
        enter(8'hE0); prog(sa(2), 8'h02); wr(12'h000, 8'hA0); wr(12'h000, 8'hF0);
        enter(8'h77); wr(12'h000, 8'hF0);
        enter(8'hC0); wr(12'h000, 8'h80); wr(12'h001, 8'h30); wr(12'h000, 8'hF0);
        enter(8'h40); wr(12'h000, 8'hF0);
        enter(8'h60); wr(12'h000, 8'h25);
        for (int i = 0; i < 8; i++) wr(12'(i), 8'hF0);
        wr(12'h000, 8'h28); wr(12'h000, 8'hF0);

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule